// File: doc/BRIEF.md
# Configurable Entropy Sampling Core

The block collects bits from one of four selectable sources into a 16-bit shift history. A sample can be taken in two ways. When the core is enabled, a counter compared against a programmable divider takes samples periodically. A rising edge on a step control bit takes a single sample on demand. On each sample, a 16-bit LFSR advances one step and the chosen bit enters the history at its least significant end. The two halves of the history are presented as raw output bytes.

Eight oscillator bits come in from outside the block. Each one is synchronised through two flops and then gated by its own enable mask bit before the source is selected. A status byte packs several values:

- the enable,
- whether a sample fired in the previous cycle,
- whether any oscillator is enabled,
- the source select,
- the low three mode bits.

A soft reset bit holds the whole sampling state in its cleared condition for as long as it stays high.

Control is a three-state machine. ST_HOLD is entered on the hardware reset and whenever the soft reset bit is high. ST_IDLE is entered when the core is not held and the enable is low. ST_RUN is entered when the enable is high. Each clock edge moves the machine to the state its inputs select: soft reset high goes to ST_HOLD, otherwise enable high goes to ST_RUN, otherwise ST_IDLE. The transitions are HOLD→IDLE, HOLD→RUN, IDLE→RUN, RUN→IDLE, and IDLE/RUN→HOLD. The counter runs only in ST_RUN. Step samples are accepted in ST_IDLE and ST_RUN.

Top module: `es_sampler`

## Requirements
- R1: While rst_n is low, raw_lo, raw_hi and status are 0x00, and the LFSR holds the seed 0x1ACE.
- R2: With the core in ST_RUN and the divider set to D, a sample fires every D+1 cycles. The counter returns to zero on every sample.
- R3: While ctl_en and ctl_step stay low, raw_lo and raw_hi do not change, whatever the oscillator inputs do.
- R4: A 0→1 transition of ctl_step takes exactly one sample on the next clock edge, in either state. Holding ctl_step high takes no further samples.
- R5: The LFSR shifts left, and bit15^bit13^bit12^bit10 enters at bit 0. Source 0 shifts in LFSR bit 0 before the advance. After reset, four steps on source 0 give the histories 0x0000, 0x0001, 0x0003 and 0x0007.
- R6: Source select codes: 0 = LFSR bit 0. 1 = masked oscillator 0. 2 = XOR of all masked oscillators. 3 = that XOR, XORed with LFSR bit 0 and history bit 15. sel_bit shows the currently selected bit.
- R7: Each oscillator input reaches sel_bit two clock edges after it changes. The enable mask gates each bit with no added delay.
- R8: One edge after its inputs are set, status reads {mode[2:0], src[1:0], |osc_mask, sample-fired, ctl_en}, bit 7 down to bit 0.
- R9: While ctl_srst is high, the history, status and counter clear, the LFSR reloads 0x1ACE, and step edges take no sample.
- R10: After each sample, raw_lo is history bits 7:0 and raw_hi is history bits 15:8. The newest bit is raw_lo bit 0.
- R11: Raising ctl_en with the divider at 0 first takes a periodic sample on the second clock edge. The first edge only moves the machine into ST_RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | Periodic sampling enable |
| ctl_step | input | 1 | Single-sample request, acts on its rising edge |
| ctl_srst | input | 1 | Soft reset, held while high |
| src_sel | input | 2 | Bit source select |
| div_val | input | 8 | Sample divider |
| mode_val | input | 8 | Mode field, low three bits mirrored into status |
| osc_mask | input | 8 | Per-oscillator enable mask |
| osc_raw | input | 8 | Raw oscillator bits |
| raw_lo | output | 8 | History bits 7:0 |
| raw_hi | output | 8 | History bits 15:8 |
| status | output | 8 | Packed status byte |
| sel_bit | output | 1 | Currently selected source bit |

## Verification
The block's results fall due at different times after a stimulus:

- A step edge driven between clock edges appears in the raw bytes right after the next edge.
- The status byte reflects its inputs and the previous cycle's sample flag one edge later.
- An oscillator change reaches sel_bit after two edges.
- Mask and source changes reach sel_bit at once.
- After an enable with divider D, the first periodic sample lands D+2 edges later.

The bench drives every input at the falling edge and samples at the next falling edge, so each check sits a whole number of edges after its stimulus. It also keeps a cycle-level model built from these rules and compares against it on every cycle of the vector walk.

// File: rtl/es_pkg.sv
package es_pkg;
    localparam int LFSR_W   = 16;
    localparam int HIST_W   = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'h1ACE;
    localparam int TAP_A = 15;
    localparam int TAP_B = 13;
    localparam int TAP_C = 12;
    localparam int TAP_D = 10;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_IDLE = 2'd1,
        ST_RUN  = 2'd2
    } ctl_state_e;

    typedef enum logic [1:0] {
        SRC_LFSR = 2'd0,
        SRC_OSC0 = 2'd1,
        SRC_OSCX = 2'd2,
        SRC_MIX  = 2'd3
    } src_e;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[TAP_A] ^ s[TAP_B] ^ s[TAP_C] ^ s[TAP_D]};
    endfunction
endpackage

// File: rtl/es_osc_sync.sv
module es_osc_sync #(
    parameter int OSC_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OSC_N-1:0] raw_i,
    input  logic [OSC_N-1:0] mask_i,
    output logic [OSC_N-1:0] gated_o
);
    logic [OSC_N-1:0] s1_q;
    logic [OSC_N-1:0] s2_q;

    for (genvar g = 0; g < OSC_N; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q[g] <= 1'b0;
                s2_q[g] <= 1'b0;
            end else begin
                s1_q[g] <= raw_i[g];
                s2_q[g] <= s1_q[g];
            end
        end
        assign gated_o[g] = s2_q[g] & mask_i[g];
    end

    AST_SYNC_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (s2_q == $past(s1_q))); // R7
endmodule

// File: rtl/es_sample_ctl.sv
module es_sample_ctl
    import es_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             step_i,
    input  logic             srst_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             ev_o
);
    ctl_state_e       st_q, st_d;
    logic [DIV_W-1:0] ctr_q, ctr_d;
    logic             step_q;
    logic             step_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_HOLD;
            ctr_q  <= '0;
            step_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ctr_q  <= ctr_d;
            step_q <= step_i;
        end
    end

    always_comb begin
        step_rise = step_i & ~step_q;
        ev_o      = 1'b0;
        ctr_d     = '0;
        unique case (st_q)
            ST_HOLD: ev_o = 1'b0;
            ST_IDLE: ev_o = step_rise;
            ST_RUN: begin
                ev_o  = (ctr_q >= div_i) | step_rise;
                ctr_d = ev_o ? '0 : ctr_q + DIV_W'(1);
            end
            default: ev_o = 1'b0;
        endcase
        if (srst_i) begin
            ctr_d = '0;
            st_d  = ST_HOLD;
        end else if (en_i) begin
            st_d  = ST_RUN;
        end else begin
            st_d  = ST_IDLE;
        end
    end

    AST_CTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q >= div_i) |=> (ctr_q == '0)); // R2
    AST_IDLE_CTR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RUN) |=> (ctr_q == '0)); // R3
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (st_q == ST_HOLD && !ev_o)); // R9
endmodule

// File: rtl/es_history.sv
module es_history
    import es_pkg::*;
#(
    parameter int OSC_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst_i,
    input  logic             ev_i,
    input  logic             en_i,
    input  logic [1:0]       src_i,
    input  logic [2:0]       mode_i,
    input  logic             mask_any_i,
    input  logic [OSC_N-1:0] osc_i,
    output logic [HIST_W-1:0] hist_o,
    output logic [7:0]       status_o,
    output logic             sel_o
);
    logic [LFSR_W-1:0] lfsr_q;
    logic [HIST_W-1:0] hist_q;
    logic [7:0]        status_q;
    logic              osc_x;
    src_e              src_e_w;

    assign src_e_w = src_e'(src_i);
    assign osc_x   = ^osc_i;

    always_comb begin
        unique case (src_e_w)
            SRC_LFSR: sel_o = lfsr_q[0];
            SRC_OSC0: sel_o = osc_i[0];
            SRC_OSCX: sel_o = osc_x;
            SRC_MIX:  sel_o = osc_x ^ lfsr_q[0] ^ hist_q[HIST_W-1];
            default:  sel_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q   <= LFSR_SEED;
            hist_q   <= '0;
            status_q <= '0;
        end else if (srst_i) begin
            lfsr_q   <= LFSR_SEED;
            hist_q   <= '0;
            status_q <= '0;
        end else begin
            if (ev_i) begin
                lfsr_q <= lfsr_next(lfsr_q);
                hist_q <= {hist_q[HIST_W-2:0], sel_o};
            end
            status_q <= {mode_i, src_i, mask_any_i, ev_i, en_i};
        end
    end

    assign hist_o   = hist_q;
    assign status_o = status_q;

    AST_SRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (hist_q == '0 && lfsr_q == LFSR_SEED && status_q == '0)); // R9
    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i && !srst_i) |=> (hist_q[0] == $past(sel_o) &&
                               hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]))); // R10
    AST_HIST_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_i && !srst_i) |=> $stable(hist_q)); // R3
endmodule

// File: rtl/es_sampler.sv
module es_sampler
    import es_pkg::*;
#(
    parameter int OSC_N = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_en,
    input  logic             ctl_step,
    input  logic             ctl_srst,
    input  logic [1:0]       src_sel,
    input  logic [DIV_W-1:0] div_val,
    input  logic [7:0]       mode_val,
    input  logic [OSC_N-1:0] osc_mask,
    input  logic [OSC_N-1:0] osc_raw,
    output logic [7:0]       raw_lo,
    output logic [7:0]       raw_hi,
    output logic [7:0]       status,
    output logic             sel_bit
);
    localparam int HALF = HIST_W / 2;

    logic [OSC_N-1:0]  osc_gated;
    logic              sample_ev;
    logic [HIST_W-1:0] hist;

    es_osc_sync #(.OSC_N(OSC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (osc_raw),
        .mask_i  (osc_mask),
        .gated_o (osc_gated)
    );

    es_sample_ctl #(.DIV_W(DIV_W)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ctl_en),
        .step_i (ctl_step),
        .srst_i (ctl_srst),
        .div_i  (div_val),
        .ev_o   (sample_ev)
    );

    es_history #(.OSC_N(OSC_N)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst_i     (ctl_srst),
        .ev_i       (sample_ev),
        .en_i       (ctl_en),
        .src_i      (src_sel),
        .mode_i     (mode_val[2:0]),
        .mask_any_i (|osc_mask),
        .osc_i      (osc_gated),
        .hist_o     (hist),
        .status_o   (status),
        .sel_o      (sel_bit)
    );

    assign raw_lo = hist[HALF-1:0];
    assign raw_hi = hist[HIST_W-1:HALF];

    AST_RESET_OUT: assert property (@(posedge clk)
        !rst_n |-> (raw_lo == 8'h00 && raw_hi == 8'h00 && status == 8'h00)); // R1
endmodule

// File: tb/es_sampler_tb.sv
`timescale 1ns/1ps
module es_sampler_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_en = 1'b0, ctl_step = 1'b0, ctl_srst = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [7:0] div_val = 8'd0, mode_val = 8'd0, osc_mask = 8'd0, osc_raw = 8'd0;
    logic [7:0] raw_lo, raw_hi, status;
    logic       sel_bit;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    es_sampler u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_step(ctl_step),
        .ctl_srst(ctl_srst), .src_sel(src_sel), .div_val(div_val),
        .mode_val(mode_val), .osc_mask(osc_mask), .osc_raw(osc_raw),
        .raw_lo(raw_lo), .raw_hi(raw_hi), .status(status), .sel_bit(sel_bit)
    );

    // reference model built from the requirements
    logic [15:0] m_lfsr, m_hist;
    logic [7:0]  m_ctr, m_stat, m_s1, m_s2;
    logic        m_stq;
    int          m_st;

    function automatic logic m_sel();
        logic [7:0] g;
        g = m_s2 & osc_mask;
        case (src_sel)
            2'd0: return m_lfsr[0];
            2'd1: return g[0];
            2'd2: return ^g;
            default: return (^g) ^ m_lfsr[0] ^ m_hist[15];
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        logic ev, sb;
        if (!rst_n) begin
            m_lfsr = 16'h1ACE; m_hist = 0; m_ctr = 0; m_stat = 0;
            m_s1 = 0; m_s2 = 0; m_stq = 0; m_st = 0;
        end else begin
            ev = (m_st == 2 && m_ctr >= div_val) || (m_st != 0 && ctl_step && !m_stq);
            sb = m_sel();
            if (ctl_srst) begin
                m_ctr = 0; m_hist = 0; m_stat = 0; m_lfsr = 16'h1ACE; m_st = 0;
            end else begin
                m_ctr = (m_st == 2 && !ev) ? m_ctr + 8'd1 : 8'd0;
                if (ev) begin
                    m_hist = {m_hist[14:0], sb};
                    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
                end
                m_stat = {mode_val[2:0], src_sel, |osc_mask, ev, ctl_en};
                m_st = ctl_en ? 2 : 1;
            end
            m_s2 = m_s1; m_s1 = osc_raw; m_stq = ctl_step;
        end
    end

    task automatic expect16(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_model(input string req);
        expect16({req, " raw"}, {raw_hi, raw_lo}, m_hist);
        expect16({req, " status"}, {8'h00, status}, {8'h00, m_stat});
        expect16({req, " sel"}, {15'd0, sel_bit}, {15'd0, m_sel()});
    endtask

    task automatic pulse_step();
        @(negedge clk); ctl_step = 1'b1;
        @(negedge clk); ctl_step = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    // {src[1:0], mask[7:0], ro[7:0], mode[2:0], div[7:0], en}
    localparam int NV = 6;
    localparam logic [29:0] VEC [NV] = '{
        {2'd0, 8'h01, 8'h00, 3'd1, 8'd2, 1'b1},
        {2'd1, 8'h01, 8'hA5, 3'd2, 8'd0, 1'b1},
        {2'd2, 8'hFF, 8'h5B, 3'd3, 8'd1, 1'b1},
        {2'd3, 8'h0F, 8'h3C, 3'd4, 8'd3, 1'b1},
        {2'd2, 8'h00, 8'hFF, 3'd7, 8'd0, 1'b0},
        {2'd3, 8'hC3, 8'h81, 3'd5, 8'd4, 1'b1}
    };

    initial begin : watchdog
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [15:0] snap;
        int cnt;
        repeat (3) @(negedge clk);
        // R1: reset state
        expect16("R1 raw", {raw_hi, raw_lo}, 16'h0000);
        expect16("R1 status", {8'h00, status}, 16'h0000);
        rst_n = 1'b1;

        // R5: LFSR sequence on source 0
        pulse_step(); expect16("R5 step1", {raw_hi, raw_lo}, 16'h0000);
        pulse_step(); expect16("R5 step2", {raw_hi, raw_lo}, 16'h0001);
        pulse_step(); expect16("R5 step3", {raw_hi, raw_lo}, 16'h0003);
        pulse_step(); expect16("R5 step4", {raw_hi, raw_lo}, 16'h0007);

        // R8: status layout
        @(negedge clk); mode_val = 8'hFD; src_sel = 2'd2; osc_mask = 8'h10;
        @(negedge clk); expect16("R8 status", {8'h00, status}, 16'h00B4);

        // R7: sync latency and mask gating
        src_sel = 2'd1; osc_mask = 8'h01; osc_raw = 8'h00;
        repeat (3) @(negedge clk);
        osc_raw = 8'h01;
        @(negedge clk); expect16("R7 one edge", {15'd0, sel_bit}, 16'd0);
        @(negedge clk); expect16("R7 two edges", {15'd0, sel_bit}, 16'd1);
        src_sel = 2'd2; osc_raw = 8'hFF;
        repeat (3) @(negedge clk);
        osc_mask = 8'h00; #1 expect16("R7 mask none", {15'd0, sel_bit}, 16'd0);
        osc_mask = 8'h03; #1 expect16("R7 mask two", {15'd0, sel_bit}, 16'd0);
        osc_mask = 8'h07; #1 expect16("R7 mask three", {15'd0, sel_bit}, 16'd1);

        // R4: held step gives one sample (src 1 shifts ones)
        do_reset();
        src_sel = 2'd1; osc_mask = 8'h01; osc_raw = 8'h01;
        repeat (3) @(negedge clk);
        ctl_step = 1'b1;
        @(negedge clk); expect16("R4 first edge", {raw_hi, raw_lo}, 16'h0001);
        repeat (4) @(negedge clk);
        expect16("R4 held", {raw_hi, raw_lo}, 16'h0001);
        ctl_step = 1'b0;
        @(negedge clk);

        // R11: enable latency with divider 0
        div_val = 8'd0; ctl_en = 1'b1;
        @(negedge clk); expect16("R11 edge1", {14'd0, status[1:0]}, 16'd1);
        @(negedge clk); expect16("R11 edge2", {14'd0, status[1:0]}, 16'd3);
        ctl_en = 1'b0;
        repeat (2) @(negedge clk);

        // R2: period D+1 with D=3
        div_val = 8'd3; ctl_en = 1'b1;
        @(negedge clk);
        cnt = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (status[1]) cnt++;
        end
        expect16("R2 count", 16'(cnt), 16'd5);
        ctl_en = 1'b0;
        @(negedge clk);

        // R3: disabled, oscillators toggling, raw stable
        @(negedge clk); snap = {raw_hi, raw_lo};
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); osc_raw = ~osc_raw;
        end
        expect16("R3 stable", {raw_hi, raw_lo}, snap);

        // R9: soft reset hold
        ctl_srst = 1'b1;
        pulse_step();
        expect16("R9 raw held", {raw_hi, raw_lo}, 16'h0000);
        expect16("R9 status held", {8'h00, status}, 16'h0000);
        ctl_srst = 1'b0; src_sel = 2'd0;
        pulse_step(); pulse_step();
        expect16("R9 seed reload", {raw_hi, raw_lo}, 16'h0001);

        // R6, R10: vector walk against the model
        for (int v = 0; v < NV; v++) begin
            do_reset();
            {src_sel, osc_mask, osc_raw, mode_val[2:0], div_val, ctl_en} = VEC[v];
            for (int c = 0; c < 4; c++) begin @(negedge clk); chk_model("R6"); end
            for (int s = 0; s < 3; s++) begin
                @(negedge clk); chk_model("R10"); ctl_step = 1'b1;
                @(negedge clk); chk_model("R10"); ctl_step = 1'b0;
            end
            for (int c = 0; c < 30; c++) begin
                @(negedge clk); chk_model("R6");
                osc_raw = {osc_raw[6:0], osc_raw[7] ^ osc_raw[5]};
            end
            ctl_en = 1'b0;
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule